// File: doc/BRIEF.md
# Translation Miss Control Register Updater

This block holds the small group of control registers that a processor's exception logic updates when an address translation misses. When a miss is signalled for a 32-bit virtual address, the block records the faulting address, merges the faulting page number into the page-table pointer register and into the translation-entry register, writes an exception code for a load or a store miss, saves the return PC when no exception is already being handled, raises the exception-level flag and presents the handler address on a redirect output one cycle later.

The page-table pointer register and the translation-entry register are only partly overwritten. Software-owned fields (the page-table base, the low flag nibble and the address-space identifier) survive the miss. Software loads any register through a single-cycle write port. A miss and a write arriving in the same cycle resolve in favour of the miss.

Top module: `tlb_miss_regs`

## Requirements
- R1: After reset every register output reads zero and `redirect_valid` is low.
- R2: A miss loads `fault_addr_o` with the full 32-bit faulting address.
- R3: A miss replaces bits [22:4] of `pt_ptr_o` with address bits [31:13] and keeps bits [31:23] and [3:0].
- R4: A miss replaces bits [31:13] of `xlat_entry_o` with address bits [31:13] and keeps bits [12:0], the address-space identifier.
- R5: A miss overwrites the whole of `exc_cause_o` with the code in bits [6:2] and zero elsewhere. The code is 2 for a load miss (`miss_store`=0, word 0x08) and 3 for a store miss (`miss_store`=1, word 0x0C).
- R6: A miss writes `ret_pc_o` with `miss_pc` minus 4 (modulo 2^32) when status bit 1 (exception level) was clear, and leaves it unchanged when that bit was set.
- R7: One cycle after a miss, `redirect_valid` is high for exactly one cycle. `redirect_pc` is 0x80000000 when status bit 0 was clear before the miss and 0x80000180 when it was set.
- R8: A miss sets status bit 1 and leaves every other status bit unchanged.
- R9: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_sel`: 0 fault address, 1 page-table pointer, 2 translation entry, 3 cause, 4 return PC, 5 status. Codes 6 and 7 change nothing.
- R10: A write in the same cycle as a miss is ignored, and the miss update determines every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss event this cycle |
| miss_store | input | 1 | 1 = store access, 0 = load access |
| miss_addr | input | 32 | Faulting virtual address |
| miss_pc | input | 32 | PC at the time of the miss |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| fault_addr_o | output | 32 | Faulting address register |
| pt_ptr_o | output | 32 | Page-table pointer register |
| xlat_entry_o | output | 32 | Translation entry register |
| exc_cause_o | output | 32 | Exception cause register |
| ret_pc_o | output | 32 | Exception return PC register |
| status_o | output | 32 | Status register |
| redirect_valid | output | 1 | Handler redirect strobe |
| redirect_pc | output | 32 | Handler address |

## Verification
The bench builds the block with its default parameters: a 13-bit page offset, the page field at bit 4 of the pointer register, a vector base of 0x80000000 with offset 0x180, and codes 2 and 3. These values bring in reach the exact merge boundaries at bits 13, 4 and 23, the wrap of the return PC below address 4, and both vector choices. A table of preloaded register states drives misses with both access types and with the exception-level bit both clear and set. Directed tests then cover reset, the unused select codes, and a write that collides with a miss.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t fault_addr;
        word_t pt_ptr;
        word_t xlat_entry;
        word_t cause;
        word_t ret_pc;
        word_t status;
    } ctl_regs_t;

    typedef struct packed {
        ctl_regs_t regs;
        logic      redir_vld;
        word_t     redir_pc;
    } blk_state_t;

    localparam logic [2:0] SEL_FAULT  = 3'd0;
    localparam logic [2:0] SEL_PTPTR  = 3'd1;
    localparam logic [2:0] SEL_XLAT   = 3'd2;
    localparam logic [2:0] SEL_CAUSE  = 3'd3;
    localparam logic [2:0] SEL_RETPC  = 3'd4;
    localparam logic [2:0] SEL_STATUS = 3'd5;

    localparam int unsigned EXL_BIT = 1;
    localparam int unsigned VEC_BIT = 0;
endpackage

// File: rtl/tlbm_field_merge.sv
module tlbm_field_merge
    import tlbm_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned PTR_LSB    = 4
) (
    input  word_t miss_addr,
    input  word_t old_ptr,
    input  word_t old_xlat,
    output word_t new_ptr,
    output word_t new_xlat
);
    localparam int unsigned VPN_W      = WORD_W - PAGE_SHIFT;
    localparam int unsigned SHIFT_AMT  = PAGE_SHIFT - PTR_LSB;
    localparam word_t       OFFS_MASK  = word_t'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam word_t       VPN_MASK   = ~OFFS_MASK;
    localparam word_t       PTR_FIELD  = word_t'(((64'd1 << VPN_W) - 64'd1) << PTR_LSB);

    always_comb begin
        new_ptr  = (old_ptr & ~PTR_FIELD) | ((miss_addr >> SHIFT_AMT) & PTR_FIELD);
        new_xlat = (miss_addr & VPN_MASK) | (old_xlat & OFFS_MASK);
    end
endmodule

// File: rtl/tlbm_vector_sel.sv
module tlbm_vector_sel
    import tlbm_pkg::*;
#(
    parameter word_t       VEC_BASE   = 32'h8000_0000,
    parameter word_t       VEC_OFFSET = 32'h0000_0180,
    parameter int unsigned LOAD_CODE  = 2,
    parameter int unsigned STORE_CODE = 3
) (
    input  logic  vec_alt,
    input  logic  is_store,
    output word_t handler_pc,
    output word_t cause_word
);
    localparam logic [4:0] LD_CODE5 = 5'(LOAD_CODE);
    localparam logic [4:0] ST_CODE5 = 5'(STORE_CODE);

    always_comb begin
        handler_pc = vec_alt ? (VEC_BASE + VEC_OFFSET) : VEC_BASE;
        cause_word = '0;
        cause_word[6:2] = is_store ? ST_CODE5 : LD_CODE5;
    end
endmodule

// File: rtl/tlb_miss_regs.sv
module tlb_miss_regs
    import tlbm_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned PTR_LSB    = 4,
    parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0180,
    parameter int unsigned LOAD_CODE  = 2,
    parameter int unsigned STORE_CODE = 3,
    parameter logic [31:0] PC_STEP    = 32'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss_valid,
    input  logic        miss_store,
    input  logic [31:0] miss_addr,
    input  logic [31:0] miss_pc,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] fault_addr_o,
    output logic [31:0] pt_ptr_o,
    output logic [31:0] xlat_entry_o,
    output logic [31:0] exc_cause_o,
    output logic [31:0] ret_pc_o,
    output logic [31:0] status_o,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc
);
    localparam int unsigned ASID_W = PAGE_SHIFT;

    blk_state_t st_d, st_q;
    word_t      merged_ptr, merged_xlat, vec_pc, miss_cause;

    tlbm_field_merge #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .PTR_LSB    (PTR_LSB)
    ) merge_i (
        .miss_addr (miss_addr),
        .old_ptr   (st_q.regs.pt_ptr),
        .old_xlat  (st_q.regs.xlat_entry),
        .new_ptr   (merged_ptr),
        .new_xlat  (merged_xlat)
    );

    tlbm_vector_sel #(
        .VEC_BASE   (VEC_BASE),
        .VEC_OFFSET (VEC_OFFSET),
        .LOAD_CODE  (LOAD_CODE),
        .STORE_CODE (STORE_CODE)
    ) vec_i (
        .vec_alt    (st_q.regs.status[VEC_BIT]),
        .is_store   (miss_store),
        .handler_pc (vec_pc),
        .cause_word (miss_cause)
    );

    always_comb begin
        st_d           = st_q;
        st_d.redir_vld = 1'b0;
        if (miss_valid) begin
            st_d.regs.fault_addr = miss_addr;
            st_d.regs.pt_ptr     = merged_ptr;
            st_d.regs.xlat_entry = merged_xlat;
            st_d.regs.cause      = miss_cause;
            if (!st_q.regs.status[EXL_BIT]) begin
                st_d.regs.ret_pc = miss_pc - PC_STEP;
            end
            st_d.regs.status[EXL_BIT] = 1'b1;
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = vec_pc;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_FAULT:  st_d.regs.fault_addr = wr_data;
                SEL_PTPTR:  st_d.regs.pt_ptr     = wr_data;
                SEL_XLAT:   st_d.regs.xlat_entry = wr_data;
                SEL_CAUSE:  st_d.regs.cause      = wr_data;
                SEL_RETPC:  st_d.regs.ret_pc     = wr_data;
                SEL_STATUS: st_d.regs.status     = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_addr_o   = st_q.regs.fault_addr;
    assign pt_ptr_o       = st_q.regs.pt_ptr;
    assign xlat_entry_o   = st_q.regs.xlat_entry;
    assign exc_cause_o    = st_q.regs.cause;
    assign ret_pc_o       = st_q.regs.ret_pc;
    assign status_o       = st_q.regs.status;
    assign redirect_valid = st_q.redir_vld;
    assign redirect_pc    = st_q.redir_pc;

    // Checks on the registered state against the port stimulus
    assert_fault_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> fault_addr_o == $past(miss_addr));

    assert_asid_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> xlat_entry_o[ASID_W-1:0] == $past(xlat_entry_o[ASID_W-1:0]));

    assert_ptr_low_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> pt_ptr_o[PTR_LSB-1:0] == $past(pt_ptr_o[PTR_LSB-1:0]));

    assert_retpc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && status_o[EXL_BIT]) |=> $stable(ret_pc_o));

    assert_exl_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> status_o[EXL_BIT]);

    assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> redirect_valid);

    assert_redirect_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(miss_valid));

    assert_cause_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $countones(exc_cause_o) <= 2);
endmodule

// File: tb/tlb_miss_regs_tb_top.sv
module tlb_miss_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid, miss_store, wr_en;
    logic [31:0] miss_addr, miss_pc, wr_data;
    logic [2:0]  wr_sel;
    logic [31:0] fault_addr_o, pt_ptr_o, xlat_entry_o, exc_cause_o, ret_pc_o, status_o, redirect_pc;
    logic        redirect_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tlb_miss_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_store(miss_store),
        .miss_addr(miss_addr), .miss_pc(miss_pc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fault_addr_o(fault_addr_o), .pt_ptr_o(pt_ptr_o),
        .xlat_entry_o(xlat_entry_o), .exc_cause_o(exc_cause_o),
        .ret_pc_o(ret_pc_o), .status_o(status_o),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    typedef struct packed {
        logic [31:0] status;
        logic [31:0] ptr;
        logic [31:0] xlat;
        logic [31:0] retpc;
        logic [31:0] addr;
        logic [31:0] pc;
        logic        store;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1234_5678, 32'h0040_0010, 1'b0},
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_1FFF, 32'h0000_0000, 32'hFFFF_E123, 32'h1000_0004, 1'b1},
        '{32'h0000_0002, 32'hA5A5_A5A5, 32'h0000_00AB, 32'h0BAD_0000, 32'h0000_2000, 32'h2000_0000, 1'b0},
        '{32'h0000_0003, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1111_1111, 32'h8000_0000, 32'h0000_0000, 1'b1},
        '{32'h00FF_0001, 32'h5A5A_5A5A, 32'h1234_0F0F, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0},
        '{32'hF0F0_F0F4, 32'h007F_FFF0, 32'h0000_1000, 32'h0000_0000, 32'h0000_1FFF, 32'h0000_0008, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire_miss(input logic [31:0] a, input logic [31:0] pc, input logic st);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a; miss_pc = pc; miss_store = st;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] e_ptr, e_xlat, e_cause, e_ret, e_stat, e_pc;
        rst_n = 1'b0; miss_valid = 1'b0; miss_store = 1'b0; miss_addr = '0; miss_pc = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 fault", fault_addr_o, 32'h0);
        chk("R1 ptr", pt_ptr_o, 32'h0);
        chk("R1 xlat", xlat_entry_o, 32'h0);
        chk("R1 cause", exc_cause_o, 32'h0);
        chk("R1 retpc", ret_pc_o, 32'h0);
        chk("R1 status", status_o, 32'h0);
        chk("R1 redirect", {31'b0, redirect_valid}, 32'h0);

        // Table-driven misses
        for (int i = 0; i < NVEC; i++) begin
            sw_write(3'd5, VECS[i].status);
            sw_write(3'd1, VECS[i].ptr);
            sw_write(3'd2, VECS[i].xlat);
            sw_write(3'd4, VECS[i].retpc);
            sw_write(3'd3, 32'hFFFF_FFFF);
            chk("R9 status write", status_o, VECS[i].status);
            fire_miss(VECS[i].addr, VECS[i].pc, VECS[i].store);
            e_ptr   = (VECS[i].ptr & 32'hFF80_000F) | {9'b0, VECS[i].addr[31:13], 4'b0};
            e_xlat  = {VECS[i].addr[31:13], VECS[i].xlat[12:0]};
            e_cause = VECS[i].store ? 32'h0000_000C : 32'h0000_0008;
            e_ret   = VECS[i].status[1] ? VECS[i].retpc : VECS[i].pc - 32'd4;
            e_stat  = VECS[i].status | 32'h2;
            e_pc    = VECS[i].status[0] ? 32'h8000_0180 : 32'h8000_0000;
            chk("R2 fault addr", fault_addr_o, VECS[i].addr);
            chk("R3 page-table ptr", pt_ptr_o, e_ptr);
            chk("R4 xlat entry", xlat_entry_o, e_xlat);
            chk("R5 cause", exc_cause_o, e_cause);
            chk("R6 return pc", ret_pc_o, e_ret);
            chk("R8 status", status_o, e_stat);
            chk("R7 redirect valid", {31'b0, redirect_valid}, 32'h1);
            chk("R7 redirect pc", redirect_pc, e_pc);
            @(negedge clk);
            chk("R7 redirect one cycle", {31'b0, redirect_valid}, 32'h0);
        end

        // R9: unused selects change nothing
        sw_write(3'd0, 32'h1357_9BDF);
        chk("R9 fault write", fault_addr_o, 32'h1357_9BDF);
        sw_write(3'd6, 32'hCAFE_F00D);
        sw_write(3'd7, 32'hCAFE_F00D);
        chk("R9 sel6/7 fault", fault_addr_o, 32'h1357_9BDF);
        chk("R9 sel6/7 ptr", pt_ptr_o, 32'h007F_FFF0 & 32'hFF80_000F);
        chk("R9 sel6/7 cause", exc_cause_o, 32'h0000_000C);
        chk("R9 sel6/7 status", status_o, 32'hF0F0_F0F6);

        // R10: write collides with miss
        sw_write(3'd5, 32'h0000_0000);
        sw_write(3'd4, 32'h0000_0000);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = 32'h4000_6000; miss_pc = 32'h0000_0100; miss_store = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'h7777_7777;
        @(negedge clk);
        miss_valid = 1'b0; wr_en = 1'b0;
        chk("R10 retpc from miss", ret_pc_o, 32'h0000_00FC);
        chk("R10 status from miss", status_o, 32'h0000_0002);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = 32'h0000_A000; miss_pc = 32'h0000_0200; miss_store = 1'b1;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h7777_7777;
        @(negedge clk);
        miss_valid = 1'b0; wr_en = 1'b0;
        chk("R10 fault from miss", fault_addr_o, 32'h0000_A000);
        chk("R6 retpc held with level set", ret_pc_o, 32'h0000_00FC);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule